// File: doc/BRIEF.md
# Multi-Rate Sample Word Interleaver

This block folds several narrow samples, all taken within one slow-clock period, into a single 16-bit event word for a storage path that runs at the slow rate. The rate mode sets how many channels each sample has. At the base rate the word carries one 16-channel sample. At double rate it carries two 8-channel samples. At quadruple rate it carries four 4-channel samples. The samples are not placed side by side in the word. Their bits are interleaved by channel, so each channel's consecutive samples sit in adjacent word bits.

Every slow cycle, the capture side presents all phase samples at once on one concatenated bus with a valid strobe. A start pulse given while the block is idle latches the rate mode. The mode then stays fixed until a halt pulse returns the block to idle. A matching unpacker sits behind the packer and turns each word back into the concatenated phase layout. Each word carries the mode it was packed in, so the unpacker stays correct even after a restart in a different mode.

Top module: `phase_word_weaver`

## Requirements
- R1: While reset is low, and directly after it, busy, evt_valid and rec_valid are 0, and evt_word, rec_bus and active_mode are 0.
- R2: A start pulse while idle makes busy 1 and active_mode equal to that cycle's mode_sel from the next cycle on. A halt pulse while busy makes busy 0 from the next cycle on.
- R3: While busy, changes of mode_sel and further start pulses have no effect. active_mode and the packing in use stay as latched.
- R4: smp_valid while idle produces no word (evt_valid stays 0). smp_valid while busy produces evt_valid one cycle later.
- R5: Mode code 0 (base rate) and the unused code 3 both pass phase_bus to evt_word unchanged.
- R6: Mode code 1 (double rate): phase k (k=0 earliest) occupies phase_bus[8k+7:8k]. Its channel ch goes to evt_word bit ch*2+k.
- R7: Mode code 2 (quadruple rate): phase k occupies phase_bus[4k+3:4k]. Its channel ch goes to evt_word bit ch*4+k.
- R8: evt_word keeps its last value in cycles with no new word.
- R9: Two cycles after an accepted sample, rec_valid is 1 and rec_bus equals that sample's phase_bus. The mode used is the one the word was packed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; latches mode_sel when idle |
| halt | input | 1 | Halt pulse; returns to idle |
| mode_sel | input | 2 | Rate mode: 0 base, 1 double, 2 quadruple, 3 as base |
| smp_valid | input | 1 | Phase samples on phase_bus are valid |
| phase_bus | input | 16 | Phase samples concatenated, earliest in the low bits |
| busy | output | 1 | Block is running |
| active_mode | output | 2 | Latched rate mode |
| evt_valid | output | 1 | New packed word this cycle |
| evt_word | output | 16 | Interleaved event word |
| rec_valid | output | 1 | Unpacked samples valid |
| rec_bus | output | 16 | Unpacked phase samples, same layout as phase_bus |

## Verification
busy and active_mode follow a start or halt pulse one clock edge after it. evt_word and evt_valid follow an accepted sample one edge after it, and rec_bus and rec_valid follow it two edges after. The bench drives each input on a falling edge. It checks the packed word at the next falling edge and the unpacked bus one falling edge after that, so each comparison lands in the cycle its result is due. The expected words come from hand-computed table entries and from a channel-by-phase loop in the bench, built from the bit positions in R5 to R7.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned LOG_MAXPH = 2;

  typedef enum logic [1:0] {
    RATE_1X  = 2'd0,
    RATE_2X  = 2'd1,
    RATE_4X  = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  // log2 of the phases per word; the unused code falls back to base rate
  function automatic int unsigned rate_log2(rate_e r);
    if (r == RATE_RSV) return 0;
    return int'(r);
  endfunction

  // word bit i = channel (i >> lg) of phase (i mod 2^lg)
  function automatic logic [WORD_W-1:0] weave(rate_e r, logic [WORD_W-1:0] bus);
    logic [WORD_W-1:0] w;
    int unsigned lg, chans, ch, k;
    lg    = rate_log2(r);
    chans = WORD_W >> lg;
    w     = '0;
    for (int i = 0; i < WORD_W; i++) begin
      ch   = i >> lg;
      k    = i & ((1 << lg) - 1);
      w[i] = bus[k * chans + ch];
    end
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] unweave(rate_e r, logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] b;
    int unsigned lg, chans, ch, k;
    lg    = rate_log2(r);
    chans = WORD_W >> lg;
    b     = '0;
    for (int i = 0; i < WORD_W; i++) begin
      ch = i >> lg;
      k  = i & ((1 << lg) - 1);
      b[k * chans + ch] = w[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/wpk_rate_ctrl.sv
module wpk_rate_ctrl
  import wpk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  halt,
  input  logic  [1:0] mode_sel,
  input  logic  smp_valid,
  output logic  busy,
  output rate_e rate,
  output logic  accept
);
  logic  run_q;
  rate_e rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rate_q <= RATE_1X;
    end else if (!run_q) begin
      if (start) begin
        run_q  <= 1'b1;
        rate_q <= rate_e'(mode_sel);
      end
    end else if (halt) begin
      run_q <= 1'b0;
    end
  end

  assign busy   = run_q;
  assign rate   = rate_q;
  assign accept = run_q & smp_valid;
endmodule

// File: rtl/wpk_weave_stage.sv
module wpk_weave_stage
  import wpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  rate_e             in_rate,
  input  logic [WORD_W-1:0] in_bus,
  output logic              out_valid,
  output rate_e             out_rate,
  output logic [WORD_W-1:0] out_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rate  <= RATE_1X;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_rate <= in_rate;
        out_word <= weave(in_rate, in_bus);
      end
    end
  end
endmodule

// File: rtl/wpk_unweave_stage.sv
module wpk_unweave_stage
  import wpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  rate_e             in_rate,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_bus
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bus   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bus <= unweave(in_rate, in_word);
    end
  end
endmodule

// File: rtl/phase_word_weaver.sv
module phase_word_weaver
  import wpk_pkg::*;
#(
  parameter int unsigned W = wpk_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         halt,
  input  logic [1:0]   mode_sel,
  input  logic         smp_valid,
  input  logic [W-1:0] phase_bus,
  output logic         busy,
  output logic [1:0]   active_mode,
  output logic         evt_valid,
  output logic [W-1:0] evt_word,
  output logic         rec_valid,
  output logic [W-1:0] rec_bus
);
  // named internal events for the checker
  logic  accept;
  rate_e cur_rate;
  rate_e word_rate;

  wpk_rate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
    .mode_sel(mode_sel), .smp_valid(smp_valid),
    .busy(busy), .rate(cur_rate), .accept(accept)
  );

  wpk_weave_stage u_weave (
    .clk(clk), .rst_n(rst_n), .in_valid(accept), .in_rate(cur_rate),
    .in_bus(phase_bus), .out_valid(evt_valid), .out_rate(word_rate),
    .out_word(evt_word)
  );

  wpk_unweave_stage u_unweave (
    .clk(clk), .rst_n(rst_n), .in_valid(evt_valid), .in_rate(word_rate),
    .in_word(evt_word), .out_valid(rec_valid), .out_bus(rec_bus)
  );

  assign active_mode = cur_rate;
endmodule

// File: rtl/phase_word_weaver_chk.sv
module phase_word_weaver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        halt,
  input logic [1:0]  mode_sel,
  input logic        smp_valid,
  input logic [15:0] phase_bus,
  input logic        busy,
  input logic [1:0]  active_mode,
  input logic        accept,
  input logic        evt_valid,
  input logic [15:0] evt_word,
  input logic        rec_valid,
  input logic [15:0] rec_bus
);
  assert_start_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && active_mode == $past(mode_sel)));

  assert_halt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt) |=> !busy);

  assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !halt) |=> (busy && $stable(active_mode)));

  assert_idle_no_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !evt_valid);

  assert_word_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && smp_valid) |=> evt_valid);

  assert_accept_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (busy && smp_valid));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> $stable(evt_word));

  assert_roundtrip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_bus == $past(phase_bus, 2)));

  assert_rec_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> rec_valid);
endmodule

bind phase_word_weaver phase_word_weaver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .mode_sel(mode_sel),
  .smp_valid(smp_valid), .phase_bus(phase_bus), .busy(busy),
  .active_mode(active_mode), .accept(accept), .evt_valid(evt_valid),
  .evt_word(evt_word), .rec_valid(rec_valid), .rec_bus(rec_bus)
);

// File: tb/sim_phase_word_weaver.sv
`timescale 1ns/1ps
module sim_phase_word_weaver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, halt = 1'b0, smp_valid = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [15:0] phase_bus = '0;
  logic        busy, evt_valid, rec_valid;
  logic [1:0]  active_mode;
  logic [15:0] evt_word, rec_bus;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_word_weaver u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .mode_sel(mode_sel),
    .smp_valid(smp_valid), .phase_bus(phase_bus), .busy(busy),
    .active_mode(active_mode), .evt_valid(evt_valid), .evt_word(evt_word),
    .rec_valid(rec_valid), .rec_bus(rec_bus)
  );

  // mode, phase bus, expected word (worked out by hand from R5..R7)
  localparam int NV = 10;
  localparam logic [1:0]  V_MODE [NV] = '{2'd0, 2'd3, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2};
  localparam logic [15:0] V_BUS  [NV] = '{16'h1234, 16'hBEEF, 16'h00FF, 16'hFF00, 16'h0F0F,
                                         16'h000F, 16'h00F0, 16'h0F00, 16'hF000, 16'h8421};
  localparam logic [15:0] V_EXP  [NV] = '{16'h1234, 16'hBEEF, 16'h5555, 16'hAAAA, 16'h00FF,
                                         16'h1111, 16'h2222, 16'h4444, 16'h8888, 16'h8421};

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected word built phase by phase, channel by channel
  function automatic logic [15:0] model(input logic [1:0] m, input logic [15:0] b);
    logic [15:0] r;
    int n;
    n = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    r = '0;
    for (int k = 0; k < n; k++)
      for (int ch = 0; ch < 16 / n; ch++)
        r[ch * n + k] = b[k * (16 / n) + ch];
    return r;
  endfunction

  task automatic go_mode(input logic [1:0] m);
    if (busy) begin halt = 1'b1; step(); halt = 1'b0; end
    start = 1'b1; mode_sel = m; step(); start = 1'b0;
  endtask

  // one accepted sample: check word after one edge, round trip after two
  task automatic send(input string tag, input logic [15:0] b, input logic [15:0] exp);
    smp_valid = 1'b1; phase_bus = b; step();
    smp_valid = 1'b0; phase_bus = ~b;
    check({tag, " evt_valid R4"}, {15'd0, evt_valid}, 16'd1);
    check({tag, " evt_word"}, evt_word, exp);
    step();
    check({tag, " rec_valid R9"}, {15'd0, rec_valid}, 16'd1);
    check({tag, " rec_bus R9"}, rec_bus, b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 evt_valid", {15'd0, evt_valid}, 16'd0);
    check("R1 rec_valid", {15'd0, rec_valid}, 16'd0);
    check("R1 evt_word", evt_word, 16'd0);
    check("R1 rec_bus", rec_bus, 16'd0);
    check("R1 active_mode", {14'd0, active_mode}, 16'd0);
    rst_n = 1'b1; step();
    check("R1 busy after release", {15'd0, busy}, 16'd0);

    // R4 samples while idle are dropped
    smp_valid = 1'b1; phase_bus = 16'hA5A5; step(); smp_valid = 1'b0;
    check("R4 idle evt_valid", {15'd0, evt_valid}, 16'd0);
    check("R8 idle evt_word", evt_word, 16'd0);

    // vector table, R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      if (!busy || active_mode != V_MODE[v]) begin
        go_mode(V_MODE[v]);
        check("R2 busy", {15'd0, busy}, 16'd1);
        check("R2 active_mode", {14'd0, active_mode}, {14'd0, V_MODE[v]});
      end
      send($sformatf("R5/R6/R7 vec%0d", v), V_BUS[v], V_EXP[v]);
    end

    // R8 word held while no sample arrives
    step(); step();
    check("R8 hold evt_valid", {15'd0, evt_valid}, 16'd0);
    check("R8 hold evt_word", evt_word, 16'h8421);

    // R3 mode_sel change and start while busy (latched mode 2) ignored
    mode_sel = 2'd1; start = 1'b1; step(); start = 1'b0;
    check("R3 active_mode", {14'd0, active_mode}, 16'd2);
    send("R3 packing kept", 16'h00FF, 16'h3333);

    // model-driven stream in every mode, R6 R7 R9
    for (int m = 0; m < 3; m++) begin
      go_mode(m[1:0]);
      for (int j = 0; j < 6; j++) begin
        logic [15:0] b;
        b = 16'(j * 16'h1F3B + m * 16'h0777 + 16'h0101);
        send($sformatf("R9 stream m%0d j%0d", m, j), b, model(m[1:0], b));
      end
    end

    // R9 back-to-back samples, then restart in another mode before unpack
    go_mode(2'd1);
    smp_valid = 1'b1; phase_bus = 16'hC3A1; step();
    phase_bus = 16'h1E2D; step();
    check("R6 b2b second word", evt_word, model(2'd1, 16'h1E2D));
    check("R9 b2b first rec", rec_bus, 16'hC3A1);
    phase_bus = 16'h7B40; halt = 1'b1; step();
    smp_valid = 1'b0; halt = 1'b0;
    check("R2 halt busy", {15'd0, busy}, 16'd0);
    check("R9 b2b second rec", rec_bus, 16'h1E2D);
    start = 1'b1; mode_sel = 2'd2; step(); start = 1'b0;
    check("R9 rec after restart", rec_bus, 16'h7B40);
    check("R2 new mode", {14'd0, active_mode}, 16'd2);
    step();
    check("R4 no stray word", {15'd0, evt_valid}, 16'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule